// File: doc/BRIEF.md
# SDRAM power-on initialization sequencer

This block drives the command, address and control pins of a single-data-rate SDRAM from the release of reset until the memory is ready for normal traffic. First it waits out the power-up pause. It then closes every bank with a precharge-all command, issues the required number of auto-refresh commands and programs the mode register. Every command is followed by no-operation cycles until its minimum recovery time has passed. When the last recovery time has run out, `init_done_o` goes high and stays high. The pins then rest at no-operation so that a normal-traffic controller can take over.

The clock frequency, the pause in microseconds and the precharge and refresh recovery times in nanoseconds are parameters. The block converts them to whole clock cycles when it is elaborated. The mode register recovery time, the refresh count and the order of the refresh and mode-register steps are also parameters. The mode word is built from a CAS latency, a burst length and a wrap selection. Reads, writes and periodic refresh are left to the controller that takes over.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_ni` is low, and in the cycle in which it is released, the outputs are: `cke_o`=1, `dqm_o`=1, `init_done_o`=0, no-operation on the pins (`cs_no`=0, `ras_no`=1, `cas_no`=1, `we_no`=1), `ba_o`=0 and `addr_o`=0.
- R2: The pins hold no-operation for exactly CLK_MHZ*PAUSE_US cycles after reset is released. The precharge-all command appears in the next cycle.
- R3: Precharge-all is encoded as `cs_no`=0, `ras_no`=0, `cas_no`=1, `we_no`=0, with `addr_o` bit 10 set, every other address bit clear and `ba_o`=0. It lasts one cycle.
- R4: `cke_o` is 1 in every cycle. `dqm_o` stays 1 up to and including the precharge-all cycle, and is 0 from the following cycle on.
- R5: A recovery time given in ns becomes ceil(ns*CLK_MHZ/1000) cycles, with a minimum of 1. The command after precharge-all comes exactly RP_CYC cycles after it.
- R6: Auto-refresh is encoded as `cs_no`=0, `ras_no`=0, `cas_no`=0, `we_no`=1, with `addr_o`=0 and `ba_o`=0. Exactly N_REF of them are issued. The command or completion that follows each one comes exactly RC_CYC cycles later.
- R7: Mode register set is encoded as all four command pins low, with `ba_o`=0. The `addr_o` fields are:
  - bits 2:0: burst code (1→000, 2→001, 4→010, 8→011, full page given as 0→111);
  - bit 3: wrap (1 = interleave);
  - bits 6:4: CAS latency in binary;
  - bits 11:7: zero.
- R8: When the burst length is full page, the wrap bit is written as 0 (sequential), whatever WRAP_IL says.
- R9: The command or completion after a mode register set comes exactly MRD_CYC cycles (at least 2) after it.
- R10: With MRS_FIRST=0 the order is precharge-all, the refreshes, mode register set. With MRS_FIRST=1 it is precharge-all, mode register set, the refreshes.
- R11: `init_done_o` rises exactly when the recovery time of the last command has elapsed. It then stays high, and the pins stay at no-operation with `dqm_o`=0.
- R12: Pulling `rst_ni` low at any point, including in the middle of the sequence, restarts the whole sequence from the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_o | output | 1 | Clock enable to the memory |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | ADDR_W (12) | Address / mode word |
| dqm_o | output | 1 | Data mask |
| init_done_o | output | 1 | Initialization finished, sticky until reset |

## Verification
Two conditions are hard to reach from the ports: the swapped step order with a full-page, interleave-requested mode word, and a reset that lands in the middle of the refresh phase. The bench reaches the first with a second instance that uses a short pause, MRS_FIRST=1, full-page burst and three refreshes. It reaches the second by releasing reset, running that instance into its refresh phase, and pulling reset again before a full second pass. A behavioural model builds the expected pin values for every cycle of both instances from the parameters. The bench compares them on every clock, so each recovery time is checked cycle-exact, and so is each DQM and done edge.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PALL,
    CMD_REF,
    CMD_MRS
  } cmd_e;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_PALL_W,
    ST_REF_W,
    ST_MRS_W,
    ST_DONE
  } step_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  localparam int unsigned AP_BIT = 10;

  function automatic pins_t cmd_pins(cmd_e c);
    case (c)
      CMD_PALL: return '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      CMD_REF:  return '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      CMD_MRS:  return '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      default:  return '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
  endfunction

  // round up to whole cycles, never below one
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned mhz);
    int unsigned c;
    c = (ns * mhz + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // burst length 0 selects full page
  function automatic logic [2:0] bl_code(int unsigned bl);
    case (bl)
      1:       return 3'b000;
      2:       return 3'b001;
      4:       return 3'b010;
      8:       return 3'b011;
      0:       return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int unsigned W       = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= W'(RST_VAL);
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_mode_word.sv
module sdram_init_mode_word
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned CAS_LAT   = 3,
  parameter int unsigned BURST_LEN = 4,
  parameter bit          WRAP_IL   = 1'b0
) (
  output logic [ADDR_W-1:0] word_o
);

  localparam logic [2:0] BL_BITS = bl_code(BURST_LEN);
  localparam logic [2:0] CL_BITS = 3'(CAS_LAT);

  logic wrap_bit;

  generate
    if (BURST_LEN == 0) begin : g_full_page
      assign wrap_bit = 1'b0;  // full page only runs sequential
    end else begin : g_fixed_len
      assign wrap_bit = WRAP_IL;
    end
  endgenerate

  assign word_o = {{(ADDR_W-7){1'b0}}, CL_BITS, wrap_bit, BL_BITS};

endmodule

// File: rtl/sdram_init_pin_reg.sv
module sdram_init_pin_reg
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  cmd_e              cmd_i,
  input  logic [ADDR_W-1:0] mode_word_i,
  input  logic              done_set_i,
  output logic              cke_o,
  output pins_t             pins_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dqm_o,
  output logic              done_o
);

  pins_t             pins_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;
  logic              pall_q;
  logic              dqm_q;
  logic              done_q;
  logic              cke_q;

  always_comb begin
    addr_d = '0;
    if (issue_i) begin
      case (cmd_i)
        CMD_PALL: addr_d[AP_BIT] = 1'b1;
        CMD_MRS:  addr_d = mode_word_i;
        default:  addr_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pins_q <= cmd_pins(CMD_NOP);
      addr_q <= '0;
      pall_q <= 1'b0;
      dqm_q  <= 1'b1;
      done_q <= 1'b0;
      cke_q  <= 1'b1;
    end else begin
      pins_q <= cmd_pins(issue_i ? cmd_i : CMD_NOP);
      addr_q <= addr_d;
      pall_q <= issue_i && (cmd_i == CMD_PALL);
      dqm_q  <= dqm_q & ~pall_q;  // released the cycle after precharge-all
      done_q <= done_q | done_set_i;
      cke_q  <= 1'b1;
    end
  end

  assign pins_o = pins_q;
  assign ba_o   = 2'b00;
  assign addr_o = addr_q;
  assign dqm_o  = dqm_q;
  assign done_o = done_q;
  assign cke_o  = cke_q;

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 50,
  parameter int unsigned PAUSE_US  = 100,
  parameter int unsigned RP_NS     = 20,
  parameter int unsigned RC_NS     = 70,
  parameter int unsigned MRD_CYC   = 2,
  parameter int unsigned N_REF     = 2,
  parameter bit          MRS_FIRST = 1'b0,
  parameter int unsigned CAS_LAT   = 3,
  parameter int unsigned BURST_LEN = 4,
  parameter bit          WRAP_IL   = 1'b0,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              cke_o,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dqm_o,
  output logic              init_done_o
);

  localparam int unsigned PAUSE_RAW = CLK_MHZ * PAUSE_US;
  localparam int unsigned PAUSE_CYC = (PAUSE_RAW == 0) ? 1 : PAUSE_RAW;
  localparam int unsigned RP_CYC    = ns_to_cyc(RP_NS, CLK_MHZ);
  localparam int unsigned RC_CYC    = ns_to_cyc(RC_NS, CLK_MHZ);
  localparam int unsigned MAX_CYC   = max4(PAUSE_CYC, RP_CYC, RC_CYC, MRD_CYC);
  localparam int unsigned TW        = $clog2(MAX_CYC + 1);
  localparam int unsigned RW        = $clog2(N_REF + 1);

  step_e             state_q, state_d;
  logic [RW-1:0]     ref_q, ref_d;
  logic              zero;
  logic              load;
  logic [TW-1:0]     load_val;
  logic              issue;
  cmd_e              cmd;
  logic              done_set;
  logic [ADDR_W-1:0] mode_word;
  pins_t             pins;

  sdram_init_timer #(
    .W       (TW),
    .RST_VAL (PAUSE_CYC - 1)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .zero_o     (zero)
  );

  sdram_init_mode_word #(
    .ADDR_W    (ADDR_W),
    .CAS_LAT   (CAS_LAT),
    .BURST_LEN (BURST_LEN),
    .WRAP_IL   (WRAP_IL)
  ) u_mode (
    .word_o (mode_word)
  );

  always_comb begin
    state_d  = state_q;
    ref_d    = ref_q;
    load     = 1'b0;
    load_val = '0;
    issue    = 1'b0;
    cmd      = CMD_NOP;
    done_set = 1'b0;
    if (zero) begin
      case (state_q)
        ST_PAUSE: begin
          issue    = 1'b1;
          cmd      = CMD_PALL;
          load     = 1'b1;
          load_val = TW'(RP_CYC - 1);
          state_d  = ST_PALL_W;
        end
        ST_PALL_W: begin
          issue = 1'b1;
          load  = 1'b1;
          if (MRS_FIRST) begin
            cmd      = CMD_MRS;
            load_val = TW'(MRD_CYC - 1);
            state_d  = ST_MRS_W;
          end else begin
            cmd      = CMD_REF;
            ref_d    = RW'(1);
            load_val = TW'(RC_CYC - 1);
            state_d  = ST_REF_W;
          end
        end
        ST_REF_W: begin
          if (ref_q < RW'(N_REF)) begin
            issue    = 1'b1;
            cmd      = CMD_REF;
            ref_d    = ref_q + 1'b1;
            load     = 1'b1;
            load_val = TW'(RC_CYC - 1);
          end else if (MRS_FIRST) begin
            done_set = 1'b1;
            state_d  = ST_DONE;
          end else begin
            issue    = 1'b1;
            cmd      = CMD_MRS;
            load     = 1'b1;
            load_val = TW'(MRD_CYC - 1);
            state_d  = ST_MRS_W;
          end
        end
        ST_MRS_W: begin
          if (MRS_FIRST) begin
            issue    = 1'b1;
            cmd      = CMD_REF;
            ref_d    = RW'(1);
            load     = 1'b1;
            load_val = TW'(RC_CYC - 1);
            state_d  = ST_REF_W;
          end else begin
            done_set = 1'b1;
            state_d  = ST_DONE;
          end
        end
        default: state_d = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PAUSE;
      ref_q   <= '0;
    end else begin
      state_q <= state_d;
      ref_q   <= ref_d;
    end
  end

  sdram_init_pin_reg #(
    .ADDR_W (ADDR_W)
  ) u_pins (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .issue_i     (issue),
    .cmd_i       (cmd),
    .mode_word_i (mode_word),
    .done_set_i  (done_set),
    .cke_o       (cke_o),
    .pins_o      (pins),
    .ba_o        (ba_o),
    .addr_o      (addr_o),
    .dqm_o       (dqm_o),
    .done_o      (init_done_o)
  );

  assign cs_no  = pins.cs_n;
  assign ras_no = pins.ras_n;
  assign cas_no = pins.cas_n;
  assign we_no  = pins.we_n;

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk
  import sdram_init_pkg::*;
#(
  parameter int unsigned PAUSE_CYC = 1,
  parameter int unsigned RP_CYC    = 1,
  parameter int unsigned RC_CYC    = 1,
  parameter int unsigned MRD_CYC   = 2,
  parameter int unsigned ADDR_W    = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cke_o,
  input logic              cs_no,
  input logic              ras_no,
  input logic              cas_no,
  input logic              we_no,
  input logic [1:0]        ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              dqm_o,
  input logic              init_done_o
);

  localparam int unsigned CW = $clog2(PAUSE_CYC + 1) + 1;

  logic          is_nop, is_cmd, is_pall, is_ref, is_mrs;
  logic [CW-1:0] cyc_q;
  logic [15:0]   gap_q;
  cmd_e          last_q;
  logic          seen_pall_q;

  assign is_nop  = !cs_no && ras_no && cas_no && we_no;
  assign is_cmd  = !cs_no && !is_nop;
  assign is_pall = !cs_no && !ras_no && cas_no && !we_no;
  assign is_ref  = !cs_no && !ras_no && !cas_no && we_no;
  assign is_mrs  = !cs_no && !ras_no && !cas_no && !we_no;

  function automatic logic [15:0] need(cmd_e c);
    case (c)
      CMD_PALL: return 16'(RP_CYC);
      CMD_REF:  return 16'(RC_CYC);
      CMD_MRS:  return 16'(MRD_CYC);
      default:  return 16'd0;
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q       <= '0;
      gap_q       <= '0;
      last_q      <= CMD_NOP;
      seen_pall_q <= 1'b0;
    end else begin
      if (cyc_q < CW'(PAUSE_CYC)) cyc_q <= cyc_q + 1'b1;
      if (is_cmd) begin
        gap_q  <= 16'd1;
        last_q <= is_pall ? CMD_PALL : is_ref ? CMD_REF : is_mrs ? CMD_MRS : CMD_NOP;
      end else if (gap_q != 16'hFFFF) begin
        gap_q <= gap_q + 1'b1;
      end
      if (is_pall) seen_pall_q <= 1'b1;
    end
  end

  p_cke_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni) cke_o);
  p_dqm_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni) !seen_pall_q |-> dqm_o);
  p_dqm_free_r4: assert property (@(posedge clk_i) disable iff (!rst_ni) seen_pall_q |-> !dqm_o);
  p_pause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_cmd |-> (cyc_q >= CW'(PAUSE_CYC)));
  p_pall_a10_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pall |-> (addr_o[AP_BIT] && ba_o == 2'b00));
  p_gap_rp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_cmd && last_q == CMD_PALL) |-> (gap_q >= 16'(RP_CYC)));
  p_gap_rc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_cmd && last_q == CMD_REF) |-> (gap_q >= 16'(RC_CYC)));
  p_gap_mrd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_cmd && last_q == CMD_MRS) |-> (gap_q >= 16'(MRD_CYC)));
  p_mrs_nop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mrs |=> is_nop);
  p_mrs_opts_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mrs |-> (addr_o[ADDR_W-1:7] == '0 && ba_o == 2'b00));
  p_done_wait_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_done_o) |-> (gap_q >= need(last_q)));
  p_done_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);
  p_done_nop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> is_nop);

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .PAUSE_CYC (PAUSE_CYC),
  .RP_CYC    (RP_CYC),
  .RC_CYC    (RC_CYC),
  .MRD_CYC   (MRD_CYC),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cke_o       (cke_o),
  .cs_no       (cs_no),
  .ras_no      (ras_no),
  .cas_no      (cas_no),
  .we_no       (we_no),
  .ba_o        (ba_o),
  .addr_o      (addr_o),
  .dqm_o       (dqm_o),
  .init_done_o (init_done_o)
);

// File: tb/sdram_init_seq_tb.sv
`timescale 1ns/1ps
module sdram_init_seq_tb;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic        cke_a, cs_a, ras_a, cas_a, we_a, dqm_a, done_a;
  logic [1:0]  ba_a;
  logic [11:0] addr_a;
  logic        cke_b, cs_b, ras_b, cas_b, we_b, dqm_b, done_b;
  logic [1:0]  ba_b;
  logic [11:0] addr_b;

  // instance A: refresh first, 8-beat interleave, CL3
  sdram_init_seq #(
    .BURST_LEN (8),
    .WRAP_IL   (1'b1)
  ) u_dut (
    .clk_i (clk), .rst_ni (rst_ni), .cke_o (cke_a), .cs_no (cs_a), .ras_no (ras_a),
    .cas_no (cas_a), .we_no (we_a), .ba_o (ba_a), .addr_o (addr_a), .dqm_o (dqm_a),
    .init_done_o (done_a)
  );

  // instance B: mode register first, full page (interleave asked), CL2
  sdram_init_seq #(
    .CLK_MHZ (50), .PAUSE_US (1), .RP_NS (45), .RC_NS (100), .MRD_CYC (3),
    .N_REF (3), .MRS_FIRST (1'b1), .CAS_LAT (2), .BURST_LEN (0), .WRAP_IL (1'b1)
  ) u_dut_b (
    .clk_i (clk), .rst_ni (rst_ni), .cke_o (cke_b), .cs_no (cs_b), .ras_no (ras_b),
    .cas_no (cas_b), .we_no (we_b), .ba_o (ba_b), .addr_o (addr_b), .dqm_o (dqm_b),
    .init_done_o (done_b)
  );

  localparam logic [3:0] P_NOP  = 4'b0111;
  localparam logic [3:0] P_PALL = 4'b0010;
  localparam logic [3:0] P_REF  = 4'b0001;
  localparam logic [3:0] P_MRS  = 4'b0000;
  localparam int         LEN    = 5020;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  string phase = "";

  logic [20:0] exp_a[$];
  logic [20:0] exp_b[$];
  string       tag_a[$];
  string       tag_b[$];
  logic [20:0] done_a_rec, done_b_rec;

  function automatic logic [20:0] rec(logic [3:0] p, logic [11:0] a, logic dqm, logic dn);
    return {1'b1, p, 2'b00, a, dqm, dn};
  endfunction

  function automatic int to_cyc(int ns, int mhz);
    int c;
    c = (ns * mhz) / 1000;
    if (c * 1000 < ns * mhz) c++;
    if (c < 1) c = 1;
    return c;
  endfunction

  task automatic add(input bit b, input logic [20:0] r, input string t, input int n);
    for (int i = 0; i < n; i++) begin
      if (b) begin exp_b.push_back(r); tag_b.push_back(t); end
      else   begin exp_a.push_back(r); tag_a.push_back(t); end
    end
  endtask

  task automatic build(input bit b, input int mhz, input int pus, input int rp_ns,
                       input int rc_ns, input int mrd, input int nref,
                       input bit mrs_first, input logic [11:0] word);
    int rp, rc;
    rp = to_cyc(rp_ns, mhz);
    rc = to_cyc(rc_ns, mhz);
    add(b, rec(P_NOP, 12'h000, 1'b1, 1'b0), "R2", mhz * pus);
    add(b, rec(P_PALL, 12'h400, 1'b1, 1'b0), "R3 R4", 1);
    add(b, rec(P_NOP, 12'h000, 1'b0, 1'b0), "R5 R4", rp - 1);
    if (mrs_first) begin
      add(b, rec(P_MRS, word, 1'b0, 1'b0), "R7 R8 R10", 1);
      add(b, rec(P_NOP, 12'h000, 1'b0, 1'b0), "R9", mrd - 1);
    end
    for (int i = 0; i < nref; i++) begin
      add(b, rec(P_REF, 12'h000, 1'b0, 1'b0), mrs_first ? "R6 R10" : "R6", 1);
      add(b, rec(P_NOP, 12'h000, 1'b0, 1'b0), "R6", rc - 1);
    end
    if (!mrs_first) begin
      add(b, rec(P_MRS, word, 1'b0, 1'b0), "R7 R10", 1);
      add(b, rec(P_NOP, 12'h000, 1'b0, 1'b0), "R9", mrd - 1);
    end
    if (b) done_b_rec = rec(P_NOP, 12'h000, 1'b0, 1'b1);
    else   done_a_rec = rec(P_NOP, 12'h000, 1'b0, 1'b1);
  endtask

  function automatic logic [20:0] act(bit b);
    if (b) return {cke_b, cs_b, ras_b, cas_b, we_b, ba_b, addr_b, dqm_b, done_b};
    return {cke_a, cs_a, ras_a, cas_a, we_a, ba_a, addr_a, dqm_a, done_a};
  endfunction

  task automatic check(input bit b, input string t, input int j,
                       input logic [20:0] e);
    logic [20:0] a;
    a = act(b);
    n_checks++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s%s inst=%0d cycle=%0d actual=%h expected=%h", phase, t, b, j, a, e);
    end
  endtask

  task automatic cmp(input int j);
    if (j < exp_a.size()) check(1'b0, tag_a[j], j, exp_a[j]);
    else                  check(1'b0, "R11", j, done_a_rec);
    if (j < exp_b.size()) check(1'b1, tag_b[j], j, exp_b[j]);
    else                  check(1'b1, "R11", j, done_b_rec);
  endtask

  task automatic chk_reset();
    check(1'b0, "R1", -1, rec(P_NOP, 12'h000, 1'b1, 1'b0));
    check(1'b1, "R1", -1, rec(P_NOP, 12'h000, 1'b1, 1'b0));
  endtask

  task automatic run(input int n);
    for (int j = 0; j < n; j++) begin
      cmp(j);
      @(negedge clk);
    end
  endtask

  task automatic reset_pulse();
    rst_ni = 1'b0;
    #1 chk_reset();
    @(negedge clk);
    chk_reset();
    @(negedge clk);
    chk_reset();
    rst_ni = 1'b1;
    #1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    // A word: CL3 (011), interleave (1), burst 8 (011) -> 0x03B
    build(1'b0, 50, 100, 20, 70, 2, 2, 1'b0, 12'h03B);
    // B word: CL2 (010), wrap forced 0, full page (111) -> 0x027
    build(1'b1, 50, 1, 45, 100, 3, 3, 1'b1, 12'h027);
    repeat (3) @(negedge clk);
    chk_reset();
    rst_ni = 1'b1;
    #1;
    run(LEN);
    phase = "R12 ";
    reset_pulse();
    run(60);  // B is in its refresh phase here
    reset_pulse();
    run(LEN);
    summary();
  end

  initial begin
    repeat (30000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

endmodule